// File: doc/BRIEF.md
# Triggered Hold and Crossing-ID Recorder

This block runs self-triggered acquisition for a many-channel front end. Any channel discriminator, or an external force-trigger, starts an event. The block then waits a programmable number of clock cycles, the shaper peaking delay, and raises a one-cycle hold on a clock edge. During that cycle a validation input decides whether the analog sample is kept.

The block counts machine crossings during an acquisition window. When the trigger is accepted, it latches the crossing number as the event tag. No finer timing is measured. A validated hold writes that tag into the time memory and moves the shared analog-memory pointer to the next cell. A hold that is not validated leaves the pointer where it is, so the cell is reused.

Once every cell is used, a full flag blocks further events. Starting the next acquisition window clears the crossing counter, the pointer and the full flag.

Top module: `hold_bx_recorder`

## Requirements
- R1: The event trigger is the OR of all `NUM_CH` channel trigger bits and `force_trig`. Any single one of them, with the others low, starts an event.
- R2: A trigger is sampled at clock edge E. `hold` is then high for exactly one cycle, starting after edge E+`peak_dly`+1, where `peak_dly` is the value present at edge E.
- R3: Suppose `hold_ok` is high during the hold cycle. In the next cycle `bcid_we` is high for exactly one cycle, and `bcid_waddr` equals the value `mem_addr` had during the hold. `mem_addr` then increases by one, unless it was already at `DEPTH`-1.
- R4: Suppose `hold_ok` is low during the hold cycle. Then `bcid_we` stays low and `mem_addr` is unchanged.
- R5: `bcid_wdata` is the number of clock edges, counted modulo 2^`BCID_W`, at which `bx_tick` was high since the window opened. The edge that samples the trigger is not counted.
- R6: An `acq_start` pulse opens the window and resets the crossing count, `mem_addr` and `mem_full` to 0. It also cancels any event in progress. Triggers are ignored before the first `acq_start` and after `acq_stop`.
- R7: `mem_full` is set by the validated write made while `mem_addr` equals `DEPTH`-1. While `mem_full` is set, `mem_addr` holds `DEPTH`-1 and no trigger causes a hold.
- R8: A trigger that arrives while an event is still waiting or holding is ignored. It causes no second hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acq_start | input | 1 | Pulse that opens an acquisition window |
| acq_stop | input | 1 | Pulse that closes the window |
| bx_tick | input | 1 | High for one cycle per bunch crossing |
| ch_trig | input | NUM_CH | Per-channel discriminator outputs |
| force_trig | input | 1 | External trigger, handled like a channel trigger |
| peak_dly | input | DLY_W | Peaking delay in clock cycles |
| hold_ok | input | 1 | Validation of the current hold |
| hold | output | 1 | One-cycle hold to the analog memories |
| mem_addr | output | AW | Current analog-memory cell |
| mem_full | output | 1 | All cells are used |
| bcid_we | output | 1 | Time-memory write strobe |
| bcid_waddr | output | AW | Time-memory write address |
| bcid_wdata | output | BCID_W | Crossing number of the event |

## Verification
The bench sweeps every channel, and the force input, with the peaking delay running across its whole range. A wrong OR reduction would leave one channel dead. An off-by-one delay counter would shift the hold by one edge. Rejected holds sit between validated ones, and a pointer that advanced on any hold would then skip cells. The bench also fills the memory to its last cell and tries one more trigger. A design that kept accepting events there would wrap the pointer or raise a hold. Finally, the bench retriggers during an event's delay and runs the crossing count past 2^`BCID_W`. A design that retriggered would produce a double hold, and a badly sized counter would tag the event with the wrong value after wraparound.

// File: rtl/hbr_pkg.sv
// Shared types for the triggered hold and crossing-ID recorder.
package hbr_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_HOLD = 2'd2
    } seq_state_t;
endpackage

// File: rtl/hbr_trig_merge.sv
// Merges the channel discriminator bits and the force input into a single
// trigger. Assumes the inputs are already synchronous to clk.
module hbr_trig_merge #(
    parameter int NUM_CH = 36
) (
    input  logic [NUM_CH-1:0] ch_trig,
    input  logic              force_trig,
    output logic              trig_any
);
    // Trigger is the OR of every channel and the force input.
    always_comb trig_any = (|ch_trig) | force_trig;
endmodule

// File: rtl/hbr_bx_window.sv
// Holds the acquisition-window flag and the crossing counter. The counter
// restarts from zero when a window opens and wraps at its width.
module hbr_bx_window #(
    parameter int BCID_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_start,
    input  logic              acq_stop,
    input  logic              bx_tick,
    output logic              acq_active,
    output logic [BCID_W-1:0] bx_count
);
    // Window flag: start takes priority over stop.
    always_ff @(posedge clk) begin
        if (!rst_n)         acq_active <= 1'b0;
        else if (acq_start) acq_active <= 1'b1;
        else if (acq_stop)  acq_active <= 1'b0;
    end

    // Crossing counter: cleared on start, counts ticks inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n)                      bx_count <= '0;
        else if (acq_start)              bx_count <= '0;
        else if (acq_active && bx_tick)  bx_count <= bx_count + 1'b1;
    end
endmodule

// File: rtl/hbr_hold_seq.sv
// Event sequencer. When armed, it accepts a trigger and latches the crossing
// tag and the peaking delay. It counts the delay down, then drives the hold
// for one cycle. Triggers that arrive while it is busy are dropped. A restart
// returns it to idle.
module hbr_hold_seq
    import hbr_pkg::*;
#(
    parameter int DLY_W  = 4,
    parameter int BCID_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              arm,
    input  logic              trig_any,
    input  logic [DLY_W-1:0]  peak_dly,
    input  logic [BCID_W-1:0] bx_count,
    input  logic              hold_ok,
    output logic              hold,
    output logic              commit,
    output logic [BCID_W-1:0] tag
);
    seq_state_t       state;
    logic [DLY_W-1:0] dly_cnt;
    logic             accept;

    // Accept a trigger only in idle with the window armed.
    always_comb accept = arm && trig_any && (state == SEQ_IDLE) && !restart;

    // State progression: idle -> wait (delay) -> hold (one cycle) -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            state <= SEQ_IDLE;
        end else begin
            unique case (state)
                SEQ_IDLE: if (accept) state <= SEQ_WAIT;
                SEQ_WAIT: if (dly_cnt == '0) state <= SEQ_HOLD;
                SEQ_HOLD: state <= SEQ_IDLE;
                default:  state <= SEQ_IDLE;
            endcase
        end
    end

    // Delay counter: loaded on accept, counts down while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      dly_cnt <= '0;
        else if (accept)                                 dly_cnt <= peak_dly;
        else if (state == SEQ_WAIT && dly_cnt != '0)     dly_cnt <= dly_cnt - 1'b1;
    end

    // Event tag: crossing number captured at the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      tag <= '0;
        else if (accept) tag <= bx_count;
    end

    // Hold decodes the state; commit marks a validated hold.
    always_comb begin
        hold   = (state == SEQ_HOLD);
        commit = hold && hold_ok && !restart;
    end
endmodule

// File: rtl/hbr_addr_ctl.sv
// Analog-memory pointer and time-memory write port. Each validated hold
// writes the tag to the current cell and steps the pointer. At the last cell
// it sets the full flag and leaves the pointer where it is. Assumes commit
// never arrives while full, since the sequencer is disarmed then.
module hbr_addr_ctl #(
    parameter int DEPTH  = 16,
    parameter int BCID_W = 24,
    parameter int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              commit,
    input  logic [BCID_W-1:0] tag,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_full,
    output logic              bcid_we,
    output logic [AW-1:0]     bcid_waddr,
    output logic [BCID_W-1:0] bcid_wdata
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Pointer and full flag: step on commit, saturate at the last cell.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            mem_addr <= '0;
            mem_full <= 1'b0;
        end else if (commit && !mem_full) begin
            if (mem_addr == LAST) mem_full <= 1'b1;
            else                  mem_addr <= mem_addr + 1'b1;
        end
    end

    // Write strobe: one cycle after each commit.
    always_ff @(posedge clk) begin
        if (!rst_n) bcid_we <= 1'b0;
        else        bcid_we <= commit && !mem_full && !restart;
    end

    // Write address and data: captured with the commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcid_waddr <= '0;
            bcid_wdata <= '0;
        end else if (commit) begin
            bcid_waddr <= mem_addr;
            bcid_wdata <= tag;
        end
    end
endmodule

// File: rtl/hold_bx_recorder.sv
// Top level of the triggered hold and crossing-ID recorder. It connects the
// trigger merge, the window/crossing counter, the event sequencer and the
// address control. All inputs are synchronous to clk.
module hold_bx_recorder #(
    parameter int NUM_CH = 36,
    parameter int BCID_W = 24,
    parameter int DEPTH  = 16,
    parameter int DLY_W  = 4,
    parameter int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_start,
    input  logic              acq_stop,
    input  logic              bx_tick,
    input  logic [NUM_CH-1:0] ch_trig,
    input  logic              force_trig,
    input  logic [DLY_W-1:0]  peak_dly,
    input  logic              hold_ok,
    output logic              hold,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_full,
    output logic              bcid_we,
    output logic [AW-1:0]     bcid_waddr,
    output logic [BCID_W-1:0] bcid_wdata
);
    logic              trig_any;
    logic              acq_active;
    logic [BCID_W-1:0] bx_count;
    logic              commit;
    logic [BCID_W-1:0] tag;
    logic              arm;

    // The sequencer is armed inside the window while cells remain.
    always_comb arm = acq_active && !mem_full;

    hbr_trig_merge #(.NUM_CH(NUM_CH)) merge_i (
        .ch_trig    (ch_trig),
        .force_trig (force_trig),
        .trig_any   (trig_any)
    );

    hbr_bx_window #(.BCID_W(BCID_W)) window_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .acq_start  (acq_start),
        .acq_stop   (acq_stop),
        .bx_tick    (bx_tick),
        .acq_active (acq_active),
        .bx_count   (bx_count)
    );

    hbr_hold_seq #(.DLY_W(DLY_W), .BCID_W(BCID_W)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (acq_start),
        .arm      (arm),
        .trig_any (trig_any),
        .peak_dly (peak_dly),
        .bx_count (bx_count),
        .hold_ok  (hold_ok),
        .hold     (hold),
        .commit   (commit),
        .tag      (tag)
    );

    hbr_addr_ctl #(.DEPTH(DEPTH), .BCID_W(BCID_W), .AW(AW)) addr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (acq_start),
        .commit     (commit),
        .tag        (tag),
        .mem_addr   (mem_addr),
        .mem_full   (mem_full),
        .bcid_we    (bcid_we),
        .bcid_waddr (bcid_waddr),
        .bcid_wdata (bcid_wdata)
    );
endmodule

// File: rtl/hbr_checker.sv
// Temporal properties of the recorder, watched at its ports. Attached to
// every instance of the top module by the bind at the end of this file.
module hbr_checker #(
    parameter int DEPTH = 16,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acq_start,
    input logic          hold,
    input logic          hold_ok,
    input logic [AW-1:0] mem_addr,
    input logic          mem_full,
    input logic          bcid_we
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    p_hold_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !hold);

    p_we_follows_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && hold_ok && !acq_start) |=> bcid_we);

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && hold_ok && !acq_start && mem_addr != LAST)
            |=> mem_addr == $past(mem_addr) + 1'b1);

    p_no_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold && hold_ok) |=> !bcid_we);

    p_addr_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !hold_ok && !acq_start) |=> $stable(mem_addr));

    p_start_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acq_start |=> (mem_addr == '0 && !mem_full && !hold));

    p_full_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_full |-> (!hold && mem_addr == LAST));
endmodule

bind hold_bx_recorder hbr_checker #(.DEPTH(DEPTH)) checker_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acq_start (acq_start),
    .hold      (hold),
    .hold_ok   (hold_ok),
    .mem_addr  (mem_addr),
    .mem_full  (mem_full),
    .bcid_we   (bcid_we)
);

// File: tb/hold_bx_recorder_tb_top.sv
`timescale 1ns/1ps
module hold_bx_recorder_tb_top;
    localparam int NUM_CH = 36;
    localparam int BCID_W = 8;
    localparam int DEPTH  = 4;
    localparam int DLY_W  = 3;
    localparam int AW     = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acq_start = 1'b0;
    logic              acq_stop = 1'b0;
    logic              bx_tick = 1'b0;
    logic [NUM_CH-1:0] ch_trig = '0;
    logic              force_trig = 1'b0;
    logic [DLY_W-1:0]  peak_dly = '0;
    logic              hold_ok = 1'b0;
    logic              hold;
    logic [AW-1:0]     mem_addr;
    logic              mem_full;
    logic              bcid_we;
    logic [AW-1:0]     bcid_waddr;
    logic [BCID_W-1:0] bcid_wdata;

    int checks = 0;
    int errors = 0;
    int ticks  = 0;

    always #2.5 clk = ~clk;

    hold_bx_recorder #(.NUM_CH(NUM_CH), .BCID_W(BCID_W), .DEPTH(DEPTH), .DLY_W(DLY_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .acq_start(acq_start), .acq_stop(acq_stop),
        .bx_tick(bx_tick), .ch_trig(ch_trig), .force_trig(force_trig),
        .peak_dly(peak_dly), .hold_ok(hold_ok), .hold(hold), .mem_addr(mem_addr),
        .mem_full(mem_full), .bcid_we(bcid_we), .bcid_waddr(bcid_waddr),
        .bcid_wdata(bcid_wdata)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic pulse_start();
        acq_start = 1'b1; @(negedge clk); acq_start = 1'b0;
        ticks = 0;
    endtask

    task automatic give_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bx_tick = 1'b1; @(negedge clk);
        end
        bx_tick = 1'b0;
        ticks += n;
    endtask

    // Expects no hold for a number of cycles.
    task automatic no_hold(input string req, input int cyc);
        int seen = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (hold) seen++;
        end
        check(req, "holds while blocked", seen, 0);
    endtask

    // One event: trigger, measure latency, validate or reject.
    task automatic do_event(input logic [NUM_CH-1:0] mask, input bit frc,
                            input int dly, input bit ok, input string req);
        int lat = 0;
        peak_dly = DLY_W'(dly); ch_trig = mask; force_trig = frc;
        @(negedge clk);
        ch_trig = '0; force_trig = 1'b0;
        while (!hold && lat < 40) begin @(negedge clk); lat++; end
        check(req, "hold latency", lat, dly + 1);
        hold_ok = ok;
        @(negedge clk);
        hold_ok = 1'b0;
        check("R2", "hold width one cycle", int'(hold), 0);
        check(ok ? "R3" : "R4", "write strobe", int'(bcid_we), int'(ok));
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R6)
        check("R6", "reset hold", int'(hold), 0);
        check("R6", "reset addr", int'(mem_addr), 0);
        check("R6", "reset full", int'(mem_full), 0);
        check("R6", "reset we", int'(bcid_we), 0);

        // R6: trigger before any window is ignored
        ch_trig[5] = 1'b1; @(negedge clk); ch_trig = '0;
        no_hold("R6", 12);

        pulse_start();
        // R1/R2/R4: every channel alone, delays swept, all rejected
        for (int c = 0; c < NUM_CH; c++) begin
            logic [NUM_CH-1:0] m = '0;
            m[c] = 1'b1;
            do_event(m, 1'b0, c % 8, 1'b0, "R1");
            check("R4", "addr after reject", int'(mem_addr), 0);
        end
        // R1: force trigger alone
        do_event('0, 1'b1, 2, 1'b0, "R1");

        // R8: retrigger during delay is dropped
        peak_dly = 3'd5; ch_trig[0] = 1'b1; @(negedge clk); ch_trig = '0;
        @(negedge clk); ch_trig[7] = 1'b1; force_trig = 1'b1;
        @(negedge clk); ch_trig = '0; force_trig = 1'b0;
        begin
            int lat = 2;
            while (!hold && lat < 40) begin @(negedge clk); lat++; end
            check("R8", "first hold latency", lat, 6);
        end
        @(negedge clk);
        no_hold("R8", 12);

        // R3/R5/R7: fill every cell with validated events
        for (int i = 0; i < DEPTH; i++) begin
            give_ticks(3 * i + 1);
            do_event(36'h1 << (i * 9), 1'b0, i, 1'b1, "R2");
            check("R3", "write address", int'(bcid_waddr), i);
            check("R5", "crossing tag", int'(bcid_wdata), ticks % 256);
            check("R3", "pointer after write", int'(mem_addr), (i < DEPTH - 1) ? i + 1 : DEPTH - 1);
            check("R7", "full flag", int'(mem_full), (i == DEPTH - 1) ? 1 : 0);
            @(negedge clk);
            check("R3", "strobe one cycle", int'(bcid_we), 0);
        end
        // R7: full blocks triggers
        ch_trig = '1; force_trig = 1'b1; @(negedge clk); ch_trig = '0; force_trig = 1'b0;
        no_hold("R7", 12);
        check("R7", "addr held when full", int'(mem_addr), DEPTH - 1);

        // R6: restart clears, stop blocks triggers
        pulse_start();
        check("R6", "addr after start", int'(mem_addr), 0);
        check("R6", "full after start", int'(mem_full), 0);
        acq_stop = 1'b1; @(negedge clk); acq_stop = 1'b0;
        ch_trig[30] = 1'b1; @(negedge clk); ch_trig = '0;
        no_hold("R6", 12);

        // R5: crossing count wraps, R4 then R3 mix
        pulse_start();
        give_ticks(258);
        do_event('0, 1'b1, 7, 1'b0, "R2");
        check("R4", "addr kept", int'(mem_addr), 0);
        do_event(36'h800000000, 1'b0, 0, 1'b1, "R2");
        check("R5", "wrapped tag", int'(bcid_wdata), 2);
        check("R3", "addr stepped", int'(mem_addr), 1);

        finish_run();
    end
endmodule